// File: doc/BRIEF.md
# Conversion Start Rate Generator

This block produces the periodic start-of-conversion strobe for an analog-to-digital converter. A free-running base clock of known frequency is divided by a divisor that software writes. Each time the programmed number of base-clock cycles has elapsed, the block raises a one-cycle start pulse.

Two 32-bit registers sit on a simple word-wide register bus. The first is read-only and reports the base-clock frequency in hertz, so driver code can derive a divisor as the integer part of that frequency divided by the wanted start rate. The second holds the divisor. A divisor of zero disables timed starts and puts the converter path into software-triggered mode. A mode flag reports that state, so a downstream FIFO can choose its packing width.

An analog-input reset command from elsewhere on the chip clears the divisor, which stops the timer.

Top module: `conv_start_timer`

## Requirements
- R1: A full-width read (bus_be = 4'b1111) at byte offset 0x0C returns the base-clock frequency parameter, which is 50,000,000 by default.
- R2: Byte offset 0x10 holds a 32-bit divisor. A full-width write stores all 32 bits, and a full-width read there returns the stored value.
- R3: Any access with bus_be other than 4'b1111 is ignored. A write leaves the divisor and the pulse phase untouched, and a read returns zero.
- R4: With a divisor N of 1 or more, start_pulse is high for exactly one cycle in every N. It is a registered output: it first goes high after the N-th rising edge that follows the write edge, and then again every N edges.
- R5: A divisor of 1 drives start_pulse high on every cycle, starting with the cycle after the first edge that follows the write.
- R6: An accepted divisor write restarts the count from zero. start_pulse is low in the cycle that follows the write edge, and any phase built up before the write is discarded.
- R7: While the divisor is zero, start_pulse stays low and sw_mode is high. sw_mode is low whenever the divisor is nonzero.
- R8: A high ain_clear at a rising edge sets the divisor to zero and drops start_pulse. It takes priority over a divisor write in the same cycle.
- R9: After reset the divisor reads zero, sw_mode is high and start_pulse is low.
- R10: Reads at any offset other than 0x0C and 0x10 return zero. Writes to such offsets change nothing.
- R11: A divisor computed as floor(base frequency / target rate) gives a pulse period of exactly that many base-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ain_clear | input | 1 | Analog-input reset command, one cycle wide |
| start_pulse | output | 1 | One-cycle start-of-conversion strobe |
| sw_mode | output | 1 | High while the divisor is zero |

## Verification
The assertions assume that bus_sel, bus_wr, bus_be and ain_clear are clean levels, sampled once per rising edge, and that a write lasts exactly one cycle. They also assume that reads have no side effects, so a read strobe may be held on any cycle. The bench changes every input only at the falling edge and holds each write for a single rising edge. It reads registers by sampling the combinational read data shortly after a falling edge, then releases the strobe before the next rising edge. This keeps every stimulus inside the single-cycle access model that the properties rely on.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BE_W     = WORD_W / 8;
  localparam logic [7:0]  OFS_FREQ = 8'h0C;
  localparam logic [7:0]  OFS_DIV  = 8'h10;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FREQ = 2'd1,
    SEL_DIV  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/cst_rst_sync.sv
module cst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cst_regs.sv
module cst_regs
  import cst_pkg::*;
#(
  parameter int unsigned          ADDR_W  = 8,
  parameter logic [WORD_W-1:0]    BASE_HZ = 32'd50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ain_clear,
  output logic [WORD_W-1:0] div_o,
  output logic              restart_o
);
  localparam logic [BE_W-1:0] FULL_BE = '1;

  reg_sel_e          rsel;
  logic              full_acc;
  logic              wr_div;
  logic              div_en;
  logic [WORD_W-1:0] div_d;
  logic [WORD_W-1:0] div_q;

  // address decode
  always_comb begin
    rsel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFS_FREQ)) rsel = SEL_FREQ;
    else if (bus_addr == ADDR_W'(OFS_DIV)) rsel = SEL_DIV;
  end

  assign full_acc = bus_sel && (bus_be == FULL_BE);
  assign wr_div   = full_acc && bus_wr && (rsel == SEL_DIV);

  // next state
  always_comb begin
    div_d     = div_q;
    div_en    = 1'b0;
    restart_o = 1'b0;
    if (ain_clear) begin
      div_d     = '0;
      div_en    = 1'b1;
      restart_o = 1'b1;
    end else if (wr_div) begin
      div_d     = bus_wdata;
      div_en    = 1'b1;
      restart_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (full_acc && !bus_wr) begin
      case (rsel)
        SEL_FREQ: bus_rdata = BASE_HZ;
        SEL_DIV:  bus_rdata = div_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign div_o = div_q;

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ain_clear |=> (div_q == '0));

  // R3
  partial_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_be != FULL_BE) && !ain_clear) |=> $stable(div_q));

  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (rsel != SEL_DIV) && !ain_clear) |=> $stable(div_q));
endmodule

// File: rtl/cst_ticker.sv
module cst_ticker
  import cst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] div_i,
  input  logic              restart_i,
  output logic              pulse_o
);
  logic [WORD_W-1:0] cnt_q;
  logic [WORD_W-1:0] cnt_d;
  logic              pulse_q;
  logic              pulse_d;
  logic              cnt_en;
  logic              running;
  logic              at_end;

  assign running = (div_i != '0);
  assign at_end  = (cnt_q == div_i - WORD_W'(1));
  assign cnt_en  = restart_i || running;

  // next state
  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (restart_i) begin
      cnt_d = '0;
    end else if (running) begin
      if (at_end) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + WORD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

  // R6
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0 && !pulse_q));

  // R4
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && div_i > WORD_W'(1) && !restart_i) |=> !pulse_q);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < div_i));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart_i) |=> !pulse_q);
endmodule

// File: rtl/conv_start_timer.sv
module conv_start_timer
  import cst_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [31:0]       BASE_HZ    = 32'd50_000_000,
  parameter int unsigned       SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ain_clear,
  output logic              start_pulse,
  output logic              sw_mode
);
  logic              rst_int_n;
  logic [WORD_W-1:0] div;
  logic              restart;

  cst_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cst_regs #(.ADDR_W(ADDR_W), .BASE_HZ(BASE_HZ)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ain_clear (ain_clear),
    .div_o     (div),
    .restart_o (restart)
  );

  cst_ticker u_tick (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .div_i     (div),
    .restart_i (restart),
    .pulse_o   (start_pulse)
  );

  assign sw_mode = (div == '0);

  // R7
  mode_vs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sw_mode && !restart) |=> !start_pulse);
endmodule

// File: tb/conv_start_timer_test.sv
module conv_start_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'd50_000_000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, ain_clear;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        start_pulse, sw_mode;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_start_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ain_clear(ain_clear),
    .start_pulse(start_pulse), .sw_mode(sw_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = 4'h0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    #1 d = bus_rdata;
    bus_sel = 0; bus_be = 4'h0;
  endtask

  // follow a write (c=0 now) for span cycles with period n (0 = never)
  task automatic follow(input string tag, input int n, input int span);
    for (int c = 0; c <= span; c++) begin
      if (c > 0) @(negedge clk);
      check(tag, {31'd0, start_pulse},
            {31'd0, (n > 0 && c > 0 && (c % n) == 0)});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0; ain_clear = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset state
    bus_read(8'h10, 4'hF, rd); check("R9 divisor", rd, 0);
    check("R9 sw_mode", {31'd0, sw_mode}, 1);
    check("R9 pulse", {31'd0, start_pulse}, 0);
    // R1
    bus_read(8'h0C, 4'hF, rd); check("R1 base freq", rd, BASE);
    // R7 idle, no pulses
    follow("R7 idle", 0, 30);

    // R4 / R5 / R2 sweep
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      bus_write(8'h10, n, 4'hF);
      if (n == 1) follow("R5 every cycle", 1, 20);
      else        follow("R4 period", n, 3 * n);
      check("R7 sw_mode low", {31'd0, sw_mode}, 0);
      bus_read(8'h10, 4'hF, rd); check("R2 readback", rd, n);
    end

    // R2 wide value
    @(negedge clk);
    bus_write(8'h10, 32'hA5C3_0F01, 4'hF);
    bus_read(8'h10, 4'hF, rd); check("R2 full width", rd, 32'hA5C3_0F01);

    // R6 restart mid-count
    @(negedge clk);
    bus_write(8'h10, 7, 4'hF);
    repeat (4) @(negedge clk);
    bus_write(8'h10, 5, 4'hF);
    follow("R6 restart", 5, 16);

    // R3 partial write ignored, pulse phase continues
    @(negedge clk);
    bus_write(8'h10, 4, 4'hF);          // c=0
    @(negedge clk);                     // c=1
    bus_write(8'h10, 9, 4'h3);          // c=2
    check("R3 partial pulse", {31'd0, start_pulse}, 0);
    @(negedge clk); @(negedge clk);     // c=4
    check("R3 phase kept", {31'd0, start_pulse}, 1);
    bus_read(8'h10, 4'hF, rd); check("R3 div kept", rd, 4);
    bus_read(8'h10, 4'h3, rd); check("R3 partial read", rd, 0);
    bus_read(8'h0C, 4'h1, rd); check("R3 partial freq", rd, 0);

    // R10 unmapped
    @(negedge clk);
    bus_write(8'h14, 3, 4'hF);
    bus_write(8'h0C, 3, 4'hF);
    bus_read(8'h10, 4'hF, rd); check("R10 div kept", rd, 4);
    bus_read(8'h14, 4'hF, rd); check("R10 read 14", rd, 0);
    bus_read(8'h08, 4'hF, rd); check("R10 read 08", rd, 0);
    bus_read(8'h0C, 4'hF, rd); check("R10 freq const", rd, BASE);

    // R7 zero divisor
    @(negedge clk);
    bus_write(8'h10, 0, 4'hF);
    check("R7 sw_mode", {31'd0, sw_mode}, 1);
    follow("R7 zero div", 0, 40);

    // R8 clear wins over same-cycle write
    @(negedge clk);
    bus_write(8'h10, 2, 4'hF);
    ain_clear = 1;
    bus_write(8'h10, 3, 4'hF);
    ain_clear = 0;
    bus_read(8'h10, 4'hF, rd); check("R8 cleared", rd, 0);
    check("R8 sw_mode", {31'd0, sw_mode}, 1);
    follow("R8 stopped", 0, 20);

    // R11 divisor from rate arithmetic
    begin
      int n;
      n = int'(BASE / 32'd5_000_000);
      @(negedge clk);
      bus_write(8'h10, n, 4'hF);
      follow("R11 derived rate", n, 3 * n);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule